// File: doc/BRIEF.md
# Dirty-Line Writeback Controller for a Page Buffer

This block holds the tag state of a DRAM page buffer placed in front of a slower main memory that wears out with writes. Each buffer slot records whether a page is resident, which page it holds, and whether that page already has a copy in main memory. It also keeps one dirty bit for every line of the page. A page fetched from backing storage is installed into a slot and nothing is written to main memory at that time. Write hits from the processor side mark individual lines dirty.

When a slot is evicted, the controller takes a snapshot of the slot and marks the slot empty. It then drains the snapshot into a main-memory write queue, one entry per accepted cycle. Each entry carries the page number and the line index. The final entry of an eviction also carries a last flag.

Main-memory writes are filtered in two ways. A page that already exists in main memory sends only its dirty lines. A page that has never been written to main memory sends all of its lines, because main memory holds no copy of it. A clean page that is already present produces no traffic at all. While a drain is in progress, the eviction port holds off new requests.

Top module: `hbuf_wb_ctrl`

## Requirements
- R1: After reset no slot is resident, `wq_valid` is 0 and `ev_ready` is 1.
- R2: An install never produces write-queue traffic. It clears all 16 dirty bits of the slot and records the page number and the `ins_in_main` flag.
- R3: A write hit to a resident slot sets the dirty bit of line `hit_line`. A write hit to a slot that is not resident has no effect.
- R4: Evicting a resident page with in-main flag 1 queues exactly its dirty lines, in ascending line index order.
- R5: Evicting a resident page with in-main flag 0 queues all 16 lines, 0 through 15, whatever their dirty bits.
- R6: Evicting a resident page with in-main flag 1 and no dirty lines queues nothing, and `ev_ready` stays 1.
- R7: The block offers one entry per cycle. An entry offered while `wq_ready` is 0 stays offered the next cycle with the same page, line and last values.
- R8: `wq_last` is 1 on the final entry of each eviction and 0 on every other entry.
- R9: `ev_ready` is 0 in every cycle in which an eviction is still offering entries.
- R10: After an eviction is accepted the slot is not resident. A second eviction of that slot queues nothing. A reinstall starts with every line clean.
- R11: Evicting a slot that is not resident is accepted and queues nothing.
- R12: Every entry carries the page number that was installed in the evicted slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ins_valid | input | 1 | Install a page into a slot |
| ins_slot | input | SLOT_W | Slot to install into |
| ins_page | input | PAGE_W | Page number to install |
| ins_in_main | input | 1 | 1 if the page already has a copy in main memory |
| hit_valid | input | 1 | Write hit to a buffered line |
| hit_slot | input | SLOT_W | Slot of the write hit |
| hit_line | input | LINE_W | Line index of the write hit |
| ev_valid | input | 1 | Eviction request |
| ev_slot | input | SLOT_W | Slot to evict |
| ev_ready | output | 1 | Eviction request can be accepted |
| wq_valid | output | 1 | Write-queue entry offered |
| wq_ready | input | 1 | Write queue accepts the entry |
| wq_page | output | PAGE_W | Page number of the entry |
| wq_line | output | LINE_W | Line index of the entry |
| wq_last | output | 1 | Final entry of this eviction |

## Verification
An eviction is accepted on a clock edge where both `ev_valid` and `ev_ready` are 1. Its first entry appears on the write-queue port right after that edge, because the outputs come straight from the drain register. Each later entry appears one edge after the previous entry is taken. Install and write-hit updates take effect one edge after they are driven, so a stimulus launched just after an edge is reflected in the tag state by the next eviction.

The bench drives all inputs just after the rising edge and samples the ports at the falling edge. At the moment an eviction is accepted, the driver pushes the lines it expects, computed from its own model of the tag state, into a scoreboard. A monitor pops one item on every handshake and compares it. The monitor also checks that an entry offered while `wq_ready` is low is held unchanged, and that `ev_ready` stays low while entries are offered.

// File: rtl/hbuf_pkg.sv
package hbuf_pkg;
   typedef enum logic [0:0] {
      DRN_IDLE = 1'b0,
      DRN_BUSY = 1'b1
   } drain_state_e;
endpackage

// File: rtl/hbuf_line_pick.sv
module hbuf_line_pick #(
   parameter int unsigned LINES  = 16,
   localparam int unsigned LINE_W = $clog2(LINES)
) (
   input  logic [LINES-1:0]  mask,
   output logic              any,
   output logic [LINE_W-1:0] idx,
   output logic              single
);
   always_comb begin
      idx = '0;
      for (int i = LINES - 1; i >= 0; i--) begin
         if (mask[i]) idx = LINE_W'(i);
      end
   end

   assign any    = |mask;
   assign single = any && ((mask & (mask - LINES'(1))) == '0);
endmodule

// File: rtl/hbuf_tag_store.sv
module hbuf_tag_store #(
   parameter int unsigned SLOTS  = 8,
   parameter int unsigned PAGE_W = 20,
   parameter int unsigned LINES  = 16,
   localparam int unsigned SLOT_W = $clog2(SLOTS),
   localparam int unsigned LINE_W = $clog2(LINES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ins_en,
   input  logic [SLOT_W-1:0] ins_slot,
   input  logic [PAGE_W-1:0] ins_page,
   input  logic              ins_in_main,
   input  logic              wr_en,
   input  logic [SLOT_W-1:0] wr_slot,
   input  logic [LINE_W-1:0] wr_line,
   input  logic              ev_take,
   input  logic [SLOT_W-1:0] ev_slot,
   output logic              rd_valid,
   output logic [PAGE_W-1:0] rd_page,
   output logic              rd_in_main,
   output logic [LINES-1:0]  rd_dirty
);
   logic [SLOTS-1:0]  valid_q;
   logic [SLOTS-1:0]  inmain_q;
   logic [PAGE_W-1:0] page_q  [SLOTS];
   logic [LINES-1:0]  dirty_q [SLOTS];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_q  <= '0;
         inmain_q <= '0;
         for (int s = 0; s < SLOTS; s++) begin
            page_q[s]  <= '0;
            dirty_q[s] <= '0;
         end
      end else begin
         for (int s = 0; s < SLOTS; s++) begin
            if (ins_en && (ins_slot == SLOT_W'(s))) begin
               valid_q[s]  <= 1'b1;
               inmain_q[s] <= ins_in_main;
               page_q[s]   <= ins_page;
               dirty_q[s]  <= '0;
            end else if (ev_take && (ev_slot == SLOT_W'(s))) begin
               valid_q[s] <= 1'b0;
               dirty_q[s] <= '0;
            end else if (wr_en && (wr_slot == SLOT_W'(s)) && valid_q[s]) begin
               dirty_q[s][wr_line] <= 1'b1;
            end
         end
      end
   end

   assign rd_valid   = valid_q[ev_slot];
   assign rd_page    = page_q[ev_slot];
   assign rd_in_main = inmain_q[ev_slot];
   assign rd_dirty   = dirty_q[ev_slot];

   assert_wr_sets_dirty_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && valid_q[wr_slot] && !(ins_en && ins_slot == wr_slot)
             && !(ev_take && ev_slot == wr_slot))
      |=> dirty_q[$past(wr_slot)][$past(wr_line)]);

   assert_wr_idle_slot_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !valid_q[wr_slot] && !(ins_en && ins_slot == wr_slot))
      |=> !valid_q[$past(wr_slot)]);

   assert_install_clean_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (ins_en) |=> (valid_q[$past(ins_slot)] && dirty_q[$past(ins_slot)] == '0));

   assert_evict_frees_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_take && !(ins_en && ins_slot == ev_slot)) |=> !valid_q[$past(ev_slot)]);
endmodule

// File: rtl/hbuf_drain.sv
module hbuf_drain #(
   parameter int unsigned PAGE_W     = 20,
   parameter int unsigned LINES      = 16,
   parameter bit          LINE_GRAIN = 1'b1,
   localparam int unsigned LINE_W = $clog2(LINES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              st_valid,
   input  logic [PAGE_W-1:0] st_page,
   input  logic              st_in_main,
   input  logic [LINES-1:0]  st_dirty,
   output logic              busy,
   output logic              wq_valid,
   input  logic              wq_ready,
   output logic [PAGE_W-1:0] wq_page,
   output logic [LINE_W-1:0] wq_line,
   output logic              wq_last
);
   import hbuf_pkg::*;

   drain_state_e      state_q;
   logic [LINES-1:0]  mask_q, mask_d, sel_mask;
   logic [PAGE_W-1:0] page_q;
   logic              any, single, fire;
   logic [LINE_W-1:0] idx;

   generate
      if (LINE_GRAIN) begin : g_line_grain
         assign sel_mask = !st_valid ? '0 : (st_in_main ? st_dirty : '1);
      end else begin : g_page_grain
         assign sel_mask = (!st_valid || (st_in_main && st_dirty == '0)) ? '0 : '1;
      end
   endgenerate

   hbuf_line_pick #(.LINES(LINES)) u_pick (
      .mask   (mask_q),
      .any    (any),
      .idx    (idx),
      .single (single)
   );

   assign fire = wq_valid && wq_ready;

   always_comb begin
      mask_d = mask_q;
      if (start)     mask_d = sel_mask;
      else if (fire) mask_d = mask_q & ~(LINES'(1) << idx);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= DRN_IDLE;
         mask_q  <= '0;
         page_q  <= '0;
      end else begin
         mask_q  <= mask_d;
         state_q <= (mask_d != '0) ? DRN_BUSY : DRN_IDLE;
         if (start) page_q <= st_page;
      end
   end

   assign busy     = (state_q == DRN_BUSY);
   assign wq_valid = busy && any;
   assign wq_page  = page_q;
   assign wq_line  = idx;
   assign wq_last  = wq_valid && single;

   assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (wq_valid && !wq_ready) |=> (wq_valid && $stable(wq_page) && $stable(wq_line)
                                   && $stable(wq_last)));

   assert_ascending_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && !wq_last) |=> (wq_valid && wq_line > $past(wq_line)));

   assert_last_ends_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && wq_last) |=> !wq_valid);

   assert_no_start_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
      wq_valid |-> !start);
endmodule

// File: rtl/hbuf_wb_ctrl.sv
module hbuf_wb_ctrl #(
   parameter int unsigned SLOTS      = 8,
   parameter int unsigned PAGE_W     = 20,
   parameter int unsigned LINES      = 16,
   parameter bit          LINE_GRAIN = 1'b1,
   localparam int unsigned SLOT_W = $clog2(SLOTS),
   localparam int unsigned LINE_W = $clog2(LINES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ins_valid,
   input  logic [SLOT_W-1:0] ins_slot,
   input  logic [PAGE_W-1:0] ins_page,
   input  logic              ins_in_main,
   input  logic              hit_valid,
   input  logic [SLOT_W-1:0] hit_slot,
   input  logic [LINE_W-1:0] hit_line,
   input  logic              ev_valid,
   input  logic [SLOT_W-1:0] ev_slot,
   output logic              ev_ready,
   output logic              wq_valid,
   input  logic              wq_ready,
   output logic [PAGE_W-1:0] wq_page,
   output logic [LINE_W-1:0] wq_line,
   output logic              wq_last
);
   generate
      if (SLOTS < 2 || (SLOTS & (SLOTS - 1)) != 0) begin : g_bad_slots
         $error("SLOTS must be a power of two of at least 2");
      end
      if (LINES < 2 || (LINES & (LINES - 1)) != 0) begin : g_bad_lines
         $error("LINES must be a power of two of at least 2");
      end
      if (PAGE_W < 1) begin : g_bad_page
         $error("PAGE_W must be at least 1");
      end
   endgenerate

   logic              ev_take, busy;
   logic              rd_valid, rd_in_main;
   logic [PAGE_W-1:0] rd_page;
   logic [LINES-1:0]  rd_dirty;

   assign ev_ready = !busy;
   assign ev_take  = ev_valid && ev_ready;

   hbuf_tag_store #(.SLOTS(SLOTS), .PAGE_W(PAGE_W), .LINES(LINES)) u_tags (
      .clk         (clk),
      .rst_n       (rst_n),
      .ins_en      (ins_valid),
      .ins_slot    (ins_slot),
      .ins_page    (ins_page),
      .ins_in_main (ins_in_main),
      .wr_en       (hit_valid),
      .wr_slot     (hit_slot),
      .wr_line     (hit_line),
      .ev_take     (ev_take),
      .ev_slot     (ev_slot),
      .rd_valid    (rd_valid),
      .rd_page     (rd_page),
      .rd_in_main  (rd_in_main),
      .rd_dirty    (rd_dirty)
   );

   hbuf_drain #(.PAGE_W(PAGE_W), .LINES(LINES), .LINE_GRAIN(LINE_GRAIN)) u_drain (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (ev_take),
      .st_valid   (rd_valid),
      .st_page    (rd_page),
      .st_in_main (rd_in_main),
      .st_dirty   (rd_dirty),
      .busy       (busy),
      .wq_valid   (wq_valid),
      .wq_ready   (wq_ready),
      .wq_page    (wq_page),
      .wq_line    (wq_line),
      .wq_last    (wq_last)
   );

   assert_ready_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
      wq_valid |-> !ev_ready);

   assert_last_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
      wq_last |-> wq_valid);

   assert_install_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (ins_valid && !wq_valid && !ev_take) |=> !wq_valid);

   assert_page_kept_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (wq_valid && wq_ready && !wq_last) |=> $stable(wq_page));
endmodule

// File: tb/hbuf_wb_ctrl_tb_top.sv
module hbuf_wb_ctrl_tb_top;
   localparam int SLOTS = 8, PAGE_W = 20, LINES = 16;
   localparam int SLOT_W = $clog2(SLOTS), LINE_W = $clog2(LINES);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ins_valid = 0, ins_in_main = 0, hit_valid = 0, ev_valid = 0, wq_ready = 1;
   logic [SLOT_W-1:0] ins_slot = '0, hit_slot = '0, ev_slot = '0;
   logic [PAGE_W-1:0] ins_page = '0;
   logic [LINE_W-1:0] hit_line = '0;
   logic ev_ready, wq_valid, wq_last;
   logic [PAGE_W-1:0] wq_page;
   logic [LINE_W-1:0] wq_line;

   always #4 clk = ~clk;

   hbuf_wb_ctrl #(.SLOTS(SLOTS), .PAGE_W(PAGE_W), .LINES(LINES)) dut_i (
      .clk(clk), .rst_n(rst_n),
      .ins_valid(ins_valid), .ins_slot(ins_slot), .ins_page(ins_page), .ins_in_main(ins_in_main),
      .hit_valid(hit_valid), .hit_slot(hit_slot), .hit_line(hit_line),
      .ev_valid(ev_valid), .ev_slot(ev_slot), .ev_ready(ev_ready),
      .wq_valid(wq_valid), .wq_ready(wq_ready), .wq_page(wq_page),
      .wq_line(wq_line), .wq_last(wq_last));

   int n_tests = 0, n_fail = 0, n_seen = 0;
   int rdy_mode = 0;
   logic [7:0] lfsr = 8'hA5;
   logic [PAGE_W+LINE_W:0] exp_q [$];

   logic             m_valid  [SLOTS];
   logic             m_inmain [SLOTS];
   logic [PAGE_W-1:0] m_page  [SLOTS];
   logic [LINES-1:0] m_dirty  [SLOTS];

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // ready generator: always ready or a pseudo-random stall pattern
   initial forever begin
      @(posedge clk); #1;
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      wq_ready = (rdy_mode == 0) ? 1'b1 : lfsr[0];
   end

   // monitor: compares handshakes with the scoreboard
   logic             hold_prev = 0;
   logic [PAGE_W-1:0] prev_page;
   logic [LINE_W-1:0] prev_line;
   logic             prev_last;
   initial forever begin
      @(negedge clk);
      if (rst_n) begin
         if (hold_prev)
            check(wq_valid && wq_page == prev_page && wq_line == prev_line
                  && wq_last == prev_last, "R7", "held entry", int'(wq_line), int'(prev_line));
         if (wq_valid) begin
            check(!ev_ready, "R9", "ev_ready during drain", int'(ev_ready), 0);
            if (wq_ready) begin
               n_seen++;
               if (exp_q.size() == 0) begin
                  check(1'b0, "R6", "unexpected entry", int'(wq_line), -1);
               end else begin
                  logic [PAGE_W+LINE_W:0] e;
                  e = exp_q.pop_front();
                  check(wq_page == e[PAGE_W+LINE_W:LINE_W+1], "R12", "page",
                        int'(wq_page), int'(e[PAGE_W+LINE_W:LINE_W+1]));
                  check(wq_line == e[LINE_W:1], "R4", "line order",
                        int'(wq_line), int'(e[LINE_W:1]));
                  check(wq_last == e[0], "R8", "last flag", int'(wq_last), int'(e[0]));
               end
            end
         end
         hold_prev = wq_valid && !wq_ready;
         prev_page = wq_page; prev_line = wq_line; prev_last = wq_last;
      end
   end

   task automatic tick();
      @(posedge clk); #1;
   endtask

   task automatic install(input int s, input int pg, input bit inm);
      ins_valid = 1; ins_slot = SLOT_W'(s); ins_page = PAGE_W'(pg); ins_in_main = inm;
      tick();
      ins_valid = 0;
      m_valid[s] = 1; m_page[s] = PAGE_W'(pg); m_inmain[s] = inm; m_dirty[s] = '0;
   endtask

   task automatic hit(input int s, input int ln);
      hit_valid = 1; hit_slot = SLOT_W'(s); hit_line = LINE_W'(ln);
      tick();
      hit_valid = 0;
      if (m_valid[s]) m_dirty[s][ln] = 1'b1;
   endtask

   // returns the number of entries expected from this eviction
   task automatic evict(input int s, output int n_exp);
      logic [LINES-1:0] msk;
      int top;
      ev_valid = 1; ev_slot = SLOT_W'(s);
      forever begin
         @(negedge clk);
         if (ev_ready) break;
      end
      msk = !m_valid[s] ? '0 : (m_inmain[s] ? m_dirty[s] : '1);
      top = -1; n_exp = 0;
      for (int i = 0; i < LINES; i++) if (msk[i]) begin top = i; n_exp++; end
      for (int i = 0; i < LINES; i++)
         if (msk[i]) exp_q.push_back({m_page[s], LINE_W'(i), (i == top)});
      m_valid[s] = 0; m_dirty[s] = '0;
      tick();
      ev_valid = 0;
   endtask

   task automatic drain_wait();
      forever begin
         @(negedge clk); #2;
         if (exp_q.size() == 0 && !wq_valid) break;
      end
   endtask

   task automatic run_evict(input int s, input string req);
      int base, ne;
      base = n_seen;
      evict(s, ne);
      drain_wait();
      repeat (3) tick();
      check(n_seen - base == ne, req, "entry count", n_seen - base, ne);
   endtask

   bit wd_hit = 0;
   initial begin
      #(8 * 200000);
      wd_hit = 1;
      check(1'b0, "R1", "watchdog expired", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      int b, n1, n2;
      for (int s = 0; s < SLOTS; s++) begin
         m_valid[s] = 0; m_inmain[s] = 0; m_page[s] = '0; m_dirty[s] = '0;
      end
      repeat (3) tick();
      rst_n = 1;
      @(negedge clk);
      // R1 reset state
      check(!wq_valid, "R1", "wq_valid after reset", int'(wq_valid), 0);
      check(ev_ready, "R1", "ev_ready after reset", int'(ev_ready), 1);
      tick();

      // R2: installs emit nothing
      install(0, 'h12345, 1);
      install(1, 'h000AB, 0);
      install(2, 'h0BEEF, 1);
      @(negedge clk);
      check(!wq_valid, "R2", "install traffic", int'(wq_valid), 0);
      tick();

      // R3 + R4: dirty lines of a present page, ascending, always ready
      hit(0, 15); hit(0, 3); hit(0, 7); hit(0, 3);
      run_evict(0, "R4");

      // R5: page never written to main queues all lines, with stalls (R7)
      rdy_mode = 1;
      hit(1, 2);
      run_evict(1, "R5");

      // R6: clean present page
      rdy_mode = 0;
      ev_valid = 1; ev_slot = 3'd2;
      m_valid[2] = 0;
      tick();
      ev_valid = 0;
      @(negedge clk);
      check(ev_ready && !wq_valid, "R6", "clean evict idle", int'(wq_valid), 0);
      tick();

      // R11 + R3: hit to an idle slot is ignored, evicting it yields nothing
      hit(6, 5);
      run_evict(6, "R11");

      // R10: evicted slot is empty; reinstall starts clean
      run_evict(0, "R10");
      install(0, 'h00777, 1);
      run_evict(0, "R10");

      // R2: install wipes dirty bits from an earlier tenant
      install(4, 'h00444, 1);
      hit(4, 9);
      install(4, 'h00445, 1);
      run_evict(4, "R2");

      // R8: single dirty line 0 carries last
      install(5, 'h00555, 1);
      hit(5, 0);
      run_evict(5, "R8");

      // R9 + R12: back-to-back evictions under stalls
      rdy_mode = 1;
      install(3, 'h03333, 1);
      install(7, 'h07777, 1);
      hit(3, 0); hit(3, 1); hit(7, 9); hit(7, 14);
      b = n_seen;
      evict(3, n1);
      evict(7, n2);
      drain_wait();
      repeat (3) tick();
      check(n_seen - b == n1 + n2, "R9", "back-to-back count", n_seen - b, n1 + n2);
      @(negedge clk);
      check(ev_ready, "R9", "ev_ready after drain", int'(ev_ready), 1);

      if (!wd_hit) begin
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end
endmodule